// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A requester presents the address, a write/read flag and a process ID. The walker computes the address of the entry in the top-level table, reads it through a simple read port, and checks that the entry is valid. That entry names the page holding the second-level table. A second read fetches the leaf entry, which supplies the frame number. The result is either a physical address or a fault record that carries the faulting virtual address, the process ID, the table level and the cause.

The address is cut into a 10-bit top index, a 10-bit leaf index and a 12-bit page offset. Entries are 32 bits wide, so a table of 1024 entries fills one 4 KB page. Only one walk is in flight at a time. The result is held until the requester acknowledges it.

Top module: `pt_walker`

## Requirements
- R1: After reset, and after any reset asserted during a walk, the walker is idle: `req_ready` is 1, and `mem_rd_valid`, `done_valid` and `fault_valid` are 0.
- R2: The first read uses address `{root_base[31:12], 12'h000} + 4 * vaddr[31:22]`. `root_base` is sampled in the cycle the request is accepted. The read stays asserted, with a stable address, until `mem_rsp_valid` is seen.
- R3: When the top entry is valid, the second read uses address `{top_entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R4: A valid leaf entry that allows the access gives `done_paddr = {leaf_entry[31:12], vaddr[11:0]}`.
- R5: A top entry with bit 0 (valid) clear gives a fault with `fault_level` = 1 and `fault_cause` = 0 (not present). No second read is issued. This holds even for a write access.
- R6: A leaf entry with bit 0 clear gives a fault with `fault_level` = 2 and `fault_cause` = 0.
- R7: A write to a valid leaf whose bit 1 (writable) is clear gives a fault with `fault_level` = 2 and `fault_cause` = 1. A read of the same leaf succeeds. Bit 1 of the top entry is not checked.
- R8: A fault reports the virtual address and the process ID of the request that caused it.
- R9: A request is accepted only while `req_ready` is 1, which is only when the walker is idle. A request presented during a walk has no effect on that walk's reads or result.
- R10: `done_valid` or `fault_valid`, and its payload, stay stable until `result_ack` is sampled high. The walker is idle in the following cycle.
- R11: `done_valid` and `fault_valid` are never high together.
- R12: A `mem_rsp_valid` pulse while no read is outstanding has no effect: no read is started and any held result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_base | input | 32 | Top-level table base; bits 31:12 are used |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | High when idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| req_pid | input | PID_W | Process ID of the requester |
| mem_rd_valid | output | 1 | Table read outstanding |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data is valid this cycle |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | Translation succeeded and is held |
| done_paddr | output | 32 | Physical address |
| fault_valid | output | 1 | Walk faulted; fault record is held |
| fault_vaddr | output | 32 | Faulting virtual address |
| fault_pid | output | PID_W | Process ID of the faulting request |
| fault_level | output | 2 | Level that faulted: 1 top, 2 leaf |
| fault_cause | output | 2 | 0 not present, 1 write to read-only page |
| result_ack | input | 1 | Requester takes the held result |

## Verification
The assertions assume a response comes as a single-cycle pulse. They also assume the memory answers only the read that is currently outstanding, because the address-stability property lets the walker move on in the cycle the response is seen. They also rely on `result_ack` being a level that is sampled only while a result is held. The bench memory follows these rules: it answers each read after a programmable delay of zero to seven cycles, and it drops the pulse on the following clock. Stray response pulses are injected only while the walker is idle or holding a result, which is where R12 says they must be ignored.

// File: rtl/ptw_pkg.sv
// Shared widths, entry bit positions, walk states and fault causes for the
// two-level table walker. Assumes ADDR_W = 2*IDX_W + OFF_W.
package ptw_pkg;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned OFF_W     = 12;
    localparam int unsigned IDX_W     = 10;
    localparam int unsigned PTE_W     = 32;
    localparam int unsigned FRAME_W   = ADDR_W - OFF_W;
    localparam int unsigned PTE_BYTES = PTE_W / 8;
    localparam int unsigned IDX_SHIFT = $clog2(PTE_BYTES);

    // Flag bits in the low part of an entry
    localparam int unsigned PTE_VALID_BIT = 0;
    localparam int unsigned PTE_WRITE_BIT = 1;
    localparam int unsigned PTE_REF_BIT   = 2;
    localparam int unsigned PTE_MOD_BIT   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ROOT,
        ST_RD_LEAF,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NOT_PRESENT = 2'd0,
        CAUSE_WRITE_RO    = 2'd1
    } fault_cause_e;

    typedef struct packed {
        logic [IDX_W-1:0] root_idx;
        logic [IDX_W-1:0] leaf_idx;
        logic [OFF_W-1:0] offset;
    } va_fields_t;
endpackage

// File: rtl/ptw_entry_addr.sv
// Forms the byte address of one table entry: a page-aligned table frame plus
// the index scaled by the entry size. Assumes tables are page aligned.
module ptw_entry_addr
    import ptw_pkg::*;
(
    input  logic [FRAME_W-1:0] table_frame,
    input  logic [IDX_W-1:0]   index,
    output logic [ADDR_W-1:0]  entry_addr
);
    localparam int unsigned PAD_W = ADDR_W - IDX_W;

    // Base plus scaled index
    always_comb begin
        entry_addr = {table_frame, {OFF_W{1'b0}}}
                   + ({{PAD_W{1'b0}}, index} << IDX_SHIFT);
    end
endmodule

// File: rtl/ptw_pte_check.sv
// Decodes one table entry: presence, write permission (checked only at the
// leaf level) and the frame field. Assumes the frame field sits above OFF_W.
module ptw_pte_check
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0]   pte,
    input  logic               is_leaf,
    input  logic               wr_access,
    output logic               present,
    output logic               denied,
    output logic [FRAME_W-1:0] frame
);
    logic unused_flag_bits;

    // Field extraction and permission check
    always_comb begin
        present = pte[PTE_VALID_BIT];
        denied  = is_leaf && wr_access && !pte[PTE_WRITE_BIT];
        frame   = pte[PTE_W-1:OFF_W];
    end

    // Referenced, modified and spare bits are carried but not acted on
    assign unused_flag_bits = ^{pte[OFF_W-1:PTE_WRITE_BIT+1], pte[PTE_REF_BIT], pte[PTE_MOD_BIT]};
endmodule

// File: rtl/pt_walker.sv
// Two-level table walker. It takes one request while idle, reads the top
// entry and then the leaf entry through a level-held read port, and holds a
// translation or fault record until acknowledged. Assumes the memory returns
// one single-cycle response per outstanding read.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int unsigned PID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] root_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic [PID_W-1:0]  req_pid,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_paddr,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_vaddr,
    output logic [PID_W-1:0]  fault_pid,
    output logic [1:0]        fault_level,
    output logic [1:0]        fault_cause,
    input  logic              result_ack
);
    walk_state_e        state_q, state_d;
    va_fields_t         va_q;
    logic               wr_q;
    logic [PID_W-1:0]   pid_q;
    logic [FRAME_W-1:0] root_frame_q;
    logic [FRAME_W-1:0] leaf_frame_q;
    logic [FRAME_W-1:0] pa_frame_q;
    logic [1:0]         flt_level_q;
    fault_cause_e       flt_cause_q;

    logic [ADDR_W-1:0]  root_addr, leaf_addr;
    logic               ent_present, ent_denied;
    logic [FRAME_W-1:0] ent_frame;
    logic               rsp_take;
    logic               unused_base_low;

    assign unused_base_low = ^root_base[OFF_W-1:0];

    ptw_entry_addr u_root_addr (
        .table_frame (root_frame_q),
        .index       (va_q.root_idx),
        .entry_addr  (root_addr)
    );

    ptw_entry_addr u_leaf_addr (
        .table_frame (leaf_frame_q),
        .index       (va_q.leaf_idx),
        .entry_addr  (leaf_addr)
    );

    ptw_pte_check u_check (
        .pte       (mem_rsp_data),
        .is_leaf   (state_q == ST_RD_LEAF),
        .wr_access (wr_q),
        .present   (ent_present),
        .denied    (ent_denied),
        .frame     (ent_frame)
    );

    // Response is consumed only while a read is outstanding
    assign rsp_take = mem_rsp_valid && (state_q == ST_RD_ROOT || state_q == ST_RD_LEAF);

    // Next-state selection for the walk
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_RD_ROOT;
            ST_RD_ROOT: if (rsp_take)  state_d = ent_present ? ST_RD_LEAF : ST_FAULT;
            ST_RD_LEAF: if (rsp_take)  state_d = (!ent_present || ent_denied) ? ST_FAULT : ST_DONE;
            ST_DONE,
            ST_FAULT:   if (result_ack) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q         <= '0;
            wr_q         <= 1'b0;
            pid_q        <= '0;
            root_frame_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            va_q         <= va_fields_t'(req_vaddr);
            wr_q         <= req_write;
            pid_q        <= req_pid;
            root_frame_q <= root_base[ADDR_W-1:OFF_W];
        end
    end

    // Entry results: leaf table frame, final frame and fault record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leaf_frame_q <= '0;
            pa_frame_q   <= '0;
            flt_level_q  <= 2'd0;
            flt_cause_q  <= CAUSE_NOT_PRESENT;
        end else if (rsp_take) begin
            if (state_q == ST_RD_ROOT) begin
                leaf_frame_q <= ent_frame;
                flt_level_q  <= 2'd1;
                flt_cause_q  <= CAUSE_NOT_PRESENT;
            end else begin
                pa_frame_q  <= ent_frame;
                flt_level_q <= 2'd2;
                flt_cause_q <= (ent_present && ent_denied) ? CAUSE_WRITE_RO : CAUSE_NOT_PRESENT;
            end
        end
    end

    // Port drive from state and held registers
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        mem_rd_valid = (state_q == ST_RD_ROOT) || (state_q == ST_RD_LEAF);
        mem_rd_addr  = (state_q == ST_RD_LEAF) ? leaf_addr : root_addr;
        done_valid   = (state_q == ST_DONE);
        done_paddr   = {pa_frame_q, va_q.offset};
        fault_valid  = (state_q == ST_FAULT);
        fault_vaddr  = va_q;
        fault_pid    = pid_q;
        fault_level  = flt_level_q;
        fault_cause  = flt_cause_q;
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Port-level properties of the walker, bound to every instance.
// Assumes single-cycle response pulses and a level-sampled acknowledge.
module pt_walker_chk
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_rd_valid,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rsp_valid,
    input logic              done_valid,
    input logic [ADDR_W-1:0] done_paddr,
    input logic              fault_valid,
    input logic [ADDR_W-1:0] fault_vaddr,
    input logic [1:0]        fault_level,
    input logic [1:0]        fault_cause,
    input logic              result_ack
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !mem_rd_valid && !done_valid && !fault_valid));

    a_r2_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rsp_valid) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    a_r5_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_level == 2'd1 || fault_level == 2'd2));

    a_r5_top_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_level == 2'd1) |-> (fault_cause == 2'd0));

    a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_valid && !done_valid && !fault_valid));

    a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !result_ack) |=> (done_valid && $stable(done_paddr)));

    a_r10_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !result_ack) |=>
            (fault_valid && $stable(fault_vaddr) && $stable(fault_level) && $stable(fault_cause)));

    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_valid || fault_valid) && result_ack) |=> req_ready);

    a_r11_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid));
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [7:0]  pid;
        logic [31:0] base;
        logic [31:0] top_ent;
        logic [31:0] leaf_ent;
        logic [2:0]  lat;
        logic [1:0]  kind;   // 0 ok, 1 top not present, 2 leaf not present, 3 write to read-only
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0040_3ABC, 1'b0, 8'h03, 32'h0010_0000, 32'h0020_0001, 32'h1234_5005, 3'd0, 2'd0},
        '{32'hFFFF_FFFF, 1'b1, 8'h7F, 32'h0030_0ABC, 32'h0040_0003, 32'hABCD_E00B, 3'd2, 2'd0},
        '{32'h0000_0000, 1'b0, 8'h01, 32'h0010_0000, 32'h0020_0000, 32'h0000_0000, 3'd1, 2'd1},
        '{32'h1234_5678, 1'b0, 8'h09, 32'h0011_0000, 32'h0050_0001, 32'h0000_0000, 3'd3, 2'd2},
        '{32'h8000_1FFF, 1'b1, 8'h22, 32'h0012_0000, 32'h0060_0001, 32'h0777_7005, 3'd0, 2'd3},
        '{32'h8000_1FFF, 1'b0, 8'h23, 32'h0012_0000, 32'h0060_0001, 32'h0777_7005, 3'd1, 2'd0},
        '{32'h4000_0123, 1'b1, 8'h44, 32'h0013_0000, 32'h0070_0001, 32'h0888_8003, 3'd5, 2'd0},
        '{32'hC030_2004, 1'b1, 8'h55, 32'h0014_0000, 32'h0080_0002, 32'h0999_9003, 3'd4, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_pid = '0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [31:0] done_paddr;
    logic        fault_valid;
    logic [31:0] fault_vaddr;
    logic [7:0]  fault_pid;
    logic [1:0]  fault_level;
    logic [1:0]  fault_cause;
    logic        result_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    // Memory model state
    logic        model_rsp = 1'b0;
    logic        stray_rsp = 1'b0;
    int          wait_cnt = 0;
    int          n_reads = 0;
    logic [31:0] rd_log [2];
    logic [31:0] cur_top, cur_leaf, cur_root_addr, cur_leaf_addr;
    int          cur_lat = 0;

    assign mem_rsp_valid = model_rsp | stray_rsp;

    always #10 clk = ~clk;

    pt_walker #(.PID_W(8)) uut (
        .clk, .rst_n, .root_base, .req_valid, .req_ready, .req_vaddr, .req_write,
        .req_pid, .mem_rd_valid, .mem_rd_addr, .mem_rsp_valid, .mem_rsp_data,
        .done_valid, .done_paddr, .fault_valid, .fault_vaddr, .fault_pid,
        .fault_level, .fault_cause, .result_ack
    );

    // Memory: answers an outstanding read after cur_lat cycles, one-cycle pulse
    always @(negedge clk) begin
        if (model_rsp) begin
            model_rsp = 1'b0;
            wait_cnt  = 0;
        end else if (mem_rd_valid) begin
            if (wait_cnt >= cur_lat) begin
                if (n_reads < 2) rd_log[n_reads] = mem_rd_addr;
                n_reads = n_reads + 1;
                if (mem_rd_addr == cur_root_addr)      mem_rsp_data = cur_top;
                else if (mem_rd_addr == cur_leaf_addr) mem_rsp_data = cur_leaf;
                else                                   mem_rsp_data = 32'h0;
                model_rsp = 1'b1;
            end else begin
                wait_cnt = wait_cnt + 1;
            end
        end else begin
            wait_cnt = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk({req, " req_ready"}, {31'd0, req_ready}, 32'd1);
        chk({req, " mem_rd_valid"}, {31'd0, mem_rd_valid}, 32'd0);
        chk({req, " done_valid"}, {31'd0, done_valid}, 32'd0);
        chk({req, " fault_valid"}, {31'd0, fault_valid}, 32'd0);
    endtask

    task automatic setup_mem(input vec_t v);
        cur_top       = v.top_ent;
        cur_leaf      = v.leaf_ent;
        cur_lat       = int'(v.lat);
        cur_root_addr = {v.base[31:12], 12'h000} + {20'h0, v.va[31:22], 2'b00};
        cur_leaf_addr = {v.top_ent[31:12], 12'h000} + {20'h0, v.va[21:12], 2'b00};
        n_reads       = 0;
        rd_log[0]     = 32'hx;
        rd_log[1]     = 32'hx;
    endtask

    task automatic wait_result();
        for (int k = 0; k < 64; k++) begin
            if (done_valid || fault_valid) break;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v, input bit busy_req);
        logic [31:0] exp_pa;
        int          exp_reads;
        setup_mem(v);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = v.va; req_write = v.wr; req_pid = v.pid; root_base = v.base;
        @(negedge clk);
        root_base = 32'hFFFF_F000;   // must not matter after acceptance (R2)
        if (busy_req) begin
            // R9: a second request during the walk must be ignored
            req_vaddr = ~v.va; req_write = ~v.wr; req_pid = ~v.pid;
            chk("R9 not ready while busy", {31'd0, req_ready}, 32'd0);
        end else begin
            req_valid = 1'b0;
        end
        wait_result();
        req_valid = 1'b0;
        exp_reads = (v.kind == 2'd1) ? 1 : 2;
        exp_pa    = {v.leaf_ent[31:12], v.va[11:0]};
        chk("R11 single result", {30'd0, done_valid, fault_valid},
            (v.kind == 2'd0) ? 32'd2 : 32'd1);
        chk("R2 top read address", rd_log[0], cur_root_addr);
        chk("R5 read count", n_reads, exp_reads);
        if (exp_reads == 2) chk("R3 leaf read address", rd_log[1], cur_leaf_addr);
        if (v.kind == 2'd0) begin
            chk("R4 physical address", done_paddr, exp_pa);
        end else begin
            chk("R8 fault vaddr", fault_vaddr, v.va);
            chk("R8 fault pid", {24'd0, fault_pid}, {24'd0, v.pid});
            chk((v.kind == 2'd1) ? "R5 fault level" : "R6 fault level",
                {30'd0, fault_level}, (v.kind == 2'd1) ? 32'd1 : 32'd2);
            chk((v.kind == 2'd3) ? "R7 fault cause" : "R6 fault cause",
                {30'd0, fault_cause}, (v.kind == 2'd3) ? 32'd1 : 32'd0);
        end
        // R10: held while not acknowledged
        repeat (2) @(negedge clk);
        chk("R10 result held", {30'd0, done_valid, fault_valid},
            (v.kind == 2'd0) ? 32'd2 : 32'd1);
        if (v.kind == 2'd0) chk("R10 paddr stable", done_paddr, exp_pa);
        else                chk("R10 fault vaddr stable", fault_vaddr, v.va);
        result_ack = 1'b1;
        @(negedge clk);
        result_ack = 1'b0;
        chk_idle("R10 released");
    endtask

    // Main sequence
    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], 1'b0);

        // R9: request held high during a walk does not change it
        run_vec(VECS[1], 1'b1);

        // R12: stray response while idle
        setup_mem(VECS[0]);
        stray_rsp = 1'b1;
        @(negedge clk);
        stray_rsp = 1'b0;
        @(negedge clk);
        chk_idle("R12 stray while idle");
        chk("R12 no read started", n_reads, 0);

        // R12: stray response while a result is held
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = VECS[0].va; req_write = 1'b0; req_pid = 8'h03;
        root_base = VECS[0].base;
        @(negedge clk);
        req_valid = 1'b0;
        wait_result();
        stray_rsp = 1'b1;
        @(negedge clk);
        stray_rsp = 1'b0;
        @(negedge clk);
        chk("R12 result kept", {31'd0, done_valid}, 32'd1);
        chk("R12 paddr kept", done_paddr, 32'h1234_5ABC);
        chk("R12 read count kept", n_reads, 2);
        result_ack = 1'b1;
        @(negedge clk);
        result_ack = 1'b0;

        // R1: reset during a walk
        setup_mem(VECS[6]);
        cur_lat = 7;
        req_valid = 1'b1; req_vaddr = VECS[6].va; root_base = VECS[6].base;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 read pending", {31'd0, mem_rd_valid}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 reset mid-walk");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule